// File: doc/BRIEF.md
# Shared Hardware Lock Bank

This block holds a bank of mutual-exclusion flags that several bus masters share through memory-mapped registers. Each lock has its own 32-bit word. A master takes a lock by reading the lock's word. If the read returns 0, the lock was free and now belongs to that master, because the same access marks it taken. If the read returns 1, another master holds the lock and the caller must try again later. The owner frees the lock by writing 0 to the same word.

Each master has its own port on the bank. A port is a single-cycle register bus: an address, a read strobe, a write strobe, write data, and read data that is valid in the same cycle as the strobe. State changes take effect at the next rising clock edge. When several ports read the same free lock in the same cycle, a fixed port order picks the one reader that receives 0.

A read-only status word reports the size of the bank. The number of locks is a build-time parameter and may be 32, 64, 128 or 256.

Top module: `spinlock_bank`

## Requirements
- R1: The word for lock i is at byte address 0x800 + 4*i. A read of it returns 0x00000000 when the lock is free and 0x00000001 when it is taken.
- R2: A read that returns 0 marks that lock taken at the end of the cycle, so the next read of the same lock returns 1.
- R3: Writing 0x00000000 to a taken lock's word frees it, so the next read of that lock returns 0.
- R4: Writing any nonzero value to a lock word leaves the lock's state unchanged. Reading a lock that is already taken leaves it taken.
- R5: The status word is at byte address 0x014. Bits [31:24] hold the number of locks divided by 32, which is 0x01, 0x02, 0x04 or 0x08, and all other bits read 0. Reading the status word changes no lock.
- R6: When several ports read the same free lock in the same cycle, the lowest-numbered port receives 0 and each other port receives 1. The lock ends the cycle taken.
- R7: If, in one cycle, one port wins a free lock by reading it and another port writes 0 to that lock, the lock ends the cycle taken. If a port writes 0 to a taken lock while another port reads it, the reader receives 1 and the lock ends the cycle free.
- R8: Reads of any address that is not the status word or an implemented, 4-byte-aligned lock word return 0 and change no state. This includes 0x800 + 4*NUM_LOCKS and any other address past the last lock. Writes to such addresses are ignored.
- R9: A synchronous reset frees every lock.
- R10: The highest lock, at 0x800 + 4*(NUM_LOCKS-1), is acquired and released like every other lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_rd | input | NUM_PORTS | Read strobe, one bit per port |
| bus_wr | input | NUM_PORTS | Write strobe, one bit per port |
| bus_addr | input | NUM_PORTS*AW | Byte address for each port; port p uses bits [p*AW +: AW] |
| bus_wdata | input | NUM_PORTS*32 | Write data for each port; port p uses bits [p*32 +: 32] |
| bus_rdata | output | NUM_PORTS*32 | Read data for each port, valid in the cycle of the read strobe |

## Verification
The assertions check the following on every cycle:
- a taken lock always reads 1;
- a read that returns 0 leaves its lock taken on the next cycle;
- the status word keeps its one-hot size field and zero elsewhere;
- reads that hit no register return 0;
- no two ports win the same lock in the same cycle;
- lock state holds steady in any cycle with no lock read and no write of 0.

Only the bench's scenarios can show the following:
- which port wins a tie;
- how a release and an acquire in the same cycle resolve;
- that reset frees every lock;
- that an access just past the last lock is ignored, while the highest real lock still works.

// File: rtl/spinlock_pkg.sv
package spinlock_pkg;
   localparam int unsigned STATUS_OFS = 32'h014;
   localparam int unsigned LOCK_BASE  = 32'h800;
   localparam int unsigned LOCKS_PER_UNIT = 32;

   // Size field reported in the top byte of the status word.
   function automatic logic [7:0] size_field(input int unsigned n);
      return 8'(n / LOCKS_PER_UNIT);
   endfunction

   function automatic bit legal_count(input int unsigned n);
      return (n == 32) || (n == 64) || (n == 128) || (n == 256);
   endfunction
endpackage

// File: rtl/spinlock_decode.sv
module spinlock_decode
   import spinlock_pkg::*;
#(
   parameter int unsigned AW        = 12,
   parameter int unsigned NUM_LOCKS = 32,
   localparam int unsigned IW       = $clog2(NUM_LOCKS)
) (
   input  logic [AW-1:0] addr,
   output logic          is_status,
   output logic          is_lock,
   output logic [IW-1:0] idx
);
   localparam logic [AW-1:0] BASE_A = AW'(LOCK_BASE);
   localparam logic [AW-1:0] STAT_A = AW'(STATUS_OFS);
   localparam logic [AW-1:0] LIM_A  = AW'(NUM_LOCKS);

   logic [AW-1:0] offs;
   logic [AW-1:0] word;

   always_comb begin
      offs      = addr - BASE_A;
      word      = {2'b00, offs[AW-1:2]};
      is_status = (addr == STAT_A);
      is_lock   = (addr >= BASE_A) && (offs[1:0] == 2'b00) && (word < LIM_A);
      idx       = offs[IW+1:2];
   end
endmodule

// File: rtl/spinlock_prio.sv
module spinlock_prio #(
   parameter int unsigned NUM_PORTS = 2,
   parameter bit          LOW_FIRST = 1'b1
) (
   input  logic [NUM_PORTS-1:0] req,
   output logic [NUM_PORTS-1:0] gnt
);
   generate
      if (LOW_FIRST) begin : g_low
         always_comb begin
            gnt = '0;
            for (int k = NUM_PORTS - 1; k >= 0; k--)
               if (req[k]) gnt = NUM_PORTS'(1) << k;
         end
      end else begin : g_high
         always_comb begin
            gnt = '0;
            for (int k = 0; k < NUM_PORTS; k++)
               if (req[k]) gnt = NUM_PORTS'(1) << k;
         end
      end
   endgenerate
endmodule

// File: rtl/spinlock_bank.sv
module spinlock_bank
   import spinlock_pkg::*;
#(
   parameter int unsigned NUM_LOCKS = 32,
   parameter int unsigned NUM_PORTS = 2,
   parameter int unsigned AW        = 12,
   parameter int unsigned DW        = 32
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic [NUM_PORTS-1:0]    bus_rd,
   input  logic [NUM_PORTS-1:0]    bus_wr,
   input  logic [NUM_PORTS*AW-1:0] bus_addr,
   input  logic [NUM_PORTS*DW-1:0] bus_wdata,
   output logic [NUM_PORTS*DW-1:0] bus_rdata
);
   localparam int unsigned IW = $clog2(NUM_LOCKS);
   localparam logic [7:0]  SZ = size_field(NUM_LOCKS);

   generate
      if (!legal_count(NUM_LOCKS)) begin : g_bad_count
         $error("spinlock_bank: NUM_LOCKS must be 32, 64, 128 or 256");
      end
      if (DW != 32) begin : g_bad_dw
         $error("spinlock_bank: DW must be 32");
      end
      if (NUM_PORTS < 1) begin : g_bad_ports
         $error("spinlock_bank: NUM_PORTS must be at least 1");
      end
      if ((LOCK_BASE + 4 * NUM_LOCKS) > (64'd1 << AW)) begin : g_bad_aw
         $error("spinlock_bank: AW too narrow for the lock region");
      end
   endgenerate

   logic [NUM_LOCKS-1:0] taken;
   logic [NUM_PORTS-1:0] st_hit;
   logic [NUM_PORTS-1:0] lk_hit;
   logic [IW-1:0]        lk_idx [NUM_PORTS];
   logic [NUM_PORTS-1:0] rd_req [NUM_LOCKS];
   logic [NUM_PORTS-1:0] gnt    [NUM_LOCKS];
   logic [NUM_LOCKS-1:0] rel_req;
   logic [NUM_LOCKS-1:0] taken_nxt;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_dec
      spinlock_decode #(.AW(AW), .NUM_LOCKS(NUM_LOCKS)) u_dec (
         .addr      (bus_addr[p*AW +: AW]),
         .is_status (st_hit[p]),
         .is_lock   (lk_hit[p]),
         .idx       (lk_idx[p])
      );
   end

   always_comb begin
      for (int i = 0; i < NUM_LOCKS; i++) begin
         rel_req[i] = 1'b0;
         for (int p = 0; p < NUM_PORTS; p++) begin
            rd_req[i][p] = bus_rd[p] && lk_hit[p] && (lk_idx[p] == IW'(i));
            if (bus_wr[p] && lk_hit[p] && (lk_idx[p] == IW'(i)) &&
                (bus_wdata[p*DW +: DW] == '0))
               rel_req[i] = 1'b1;
         end
      end
   end

   for (genvar i = 0; i < NUM_LOCKS; i++) begin : g_lock
      spinlock_prio #(.NUM_PORTS(NUM_PORTS), .LOW_FIRST(1'b1)) u_arb (
         .req (rd_req[i]),
         .gnt (gnt[i])
      );
      // A read of a free lock takes it; a release only frees a held lock.
      assign taken_nxt[i] = taken[i] ? ~rel_req[i] : (|rd_req[i]);
   end

   always_ff @(posedge clk) begin
      if (rst) taken <= '0;
      else     taken <= taken_nxt;
   end

   always_comb begin
      for (int p = 0; p < NUM_PORTS; p++) begin
         bus_rdata[p*DW +: DW] = '0;
         if (bus_rd[p]) begin
            if (st_hit[p])
               bus_rdata[p*DW +: DW] = {SZ, 24'h000000};
            else if (lk_hit[p])
               bus_rdata[p*DW +: DW] =
                  {31'b0, taken[lk_idx[p]] | ~gnt[lk_idx[p]][p]};
         end
      end
   end

   logic any_lock_rd;
   assign any_lock_rd = |(bus_rd & lk_hit);

   AST_QUIET_HOLD: assert property (@(posedge clk) disable iff (rst)
      (!any_lock_rd && !(|rel_req)) |=> $stable(taken)); // R4

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
      AST_TAKEN_READS_ONE: assert property (@(posedge clk) disable iff (rst)
         (bus_rd[p] && lk_hit[p] && taken[lk_idx[p]]) |->
            (bus_rdata[p*DW +: DW] == 32'd1)); // R1
      AST_GRANT_SETS: assert property (@(posedge clk) disable iff (rst)
         (bus_rd[p] && lk_hit[p] && bus_rdata[p*DW +: DW] == '0) |=>
            taken[$past(lk_idx[p])]); // R2
      AST_STATUS_FIELD: assert property (@(posedge clk) disable iff (rst)
         (bus_rd[p] && st_hit[p]) |->
            (bus_rdata[p*DW +: 24] == '0 && bus_rdata[p*DW+28 +: 4] == '0 &&
             $countones(bus_rdata[p*DW+24 +: 4]) == 1)); // R5
      AST_MISS_ZERO: assert property (@(posedge clk) disable iff (rst)
         (bus_rd[p] && !st_hit[p] && !lk_hit[p]) |->
            (bus_rdata[p*DW +: DW] == '0)); // R8
      for (genvar q = p + 1; q < NUM_PORTS; q++) begin : g_pair
         AST_ONE_WINNER: assert property (@(posedge clk) disable iff (rst)
            !(bus_rd[p] && bus_rd[q] && lk_hit[p] && lk_hit[q] &&
              lk_idx[p] == lk_idx[q] &&
              bus_rdata[p*DW +: DW] == '0 && bus_rdata[q*DW +: DW] == '0)); // R6
      end
   end
endmodule

// File: tb/sim_spinlock_bank.sv
module sim_spinlock_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NL = 32;
   localparam int NP = 2;
   localparam int AW = 12;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic [NP-1:0]    bus_rd = '0;
   logic [NP-1:0]    bus_wr = '0;
   logic [NP*AW-1:0] bus_addr = '0;
   logic [NP*32-1:0] bus_wdata = '0;
   logic [NP*32-1:0] bus_rdata;

   int checks = 0;
   int errors = 0;
   logic [31:0] r0, r1;

   always #(CLK_PERIOD/2) clk = ~clk;

   spinlock_bank #(.NUM_LOCKS(NL), .NUM_PORTS(NP), .AW(AW)) u0 (
      .clk, .rst, .bus_rd, .bus_wr, .bus_addr, .bus_wdata, .bus_rdata
   );

   function automatic logic [AW-1:0] la(input int i);
      return AW'(32'h800 + 4 * i);
   endfunction

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // One bus cycle on both ports; captures read data mid-cycle.
   task automatic cyc(input logic rd0, input logic wr0, input logic [AW-1:0] a0, input logic [31:0] d0,
                      input logic rd1, input logic wr1, input logic [AW-1:0] a1, input logic [31:0] d1);
      @(negedge clk);
      bus_rd = {rd1, rd0};
      bus_wr = {wr1, wr0};
      bus_addr = {a1, a0};
      bus_wdata = {d1, d0};
      #1;
      r0 = bus_rdata[31:0];
      r1 = bus_rdata[63:32];
      @(posedge clk);
      #1;
      bus_rd = '0;
      bus_wr = '0;
   endtask

   task automatic rd(input logic [AW-1:0] a);
      cyc(1, 0, a, 0, 0, 0, 0, 0);
   endtask

   task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
      cyc(0, 1, a, d, 0, 0, 0, 0);
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); @(negedge clk); rst = 1'b0;
   endtask

   task automatic t_reset_state();
      rd(la(0));  chk("R1 free lock 0 after reset", r0, 0);
      wr(la(0), 0);
      rd(la(5));  chk("R1 free lock 5 after reset", r0, 0);
      wr(la(5), 0);
   endtask

   task automatic t_acquire_release();
      rd(la(3));  chk("R2 first read wins", r0, 0);
      rd(la(3));  chk("R2 second read sees taken", r0, 1);
      rd(la(4));  chk("R1 neighbour still free", r0, 0);
      wr(la(3), 0);
      rd(la(3));  chk("R3 released lock reads free", r0, 0);
      wr(la(3), 0);
      wr(la(4), 0);
   endtask

   task automatic t_nonzero();
      rd(la(7));
      wr(la(7), 32'h1);
      rd(la(7));  chk("R4 nonzero write keeps taken", r0, 1);
      rd(la(7));  chk("R4 repeated read stays taken", r0, 1);
      wr(la(7), 0);
      wr(la(8), 32'hFFFF_FFFF);
      rd(la(8));  chk("R4 nonzero write does not take", r0, 0);
      wr(la(8), 0);
   endtask

   task automatic t_status();
      rd(AW'(12'h014)); chk("R5 status word", r0, 32'h0100_0000);
      rd(la(9));  chk("R5 status read left lock free", r0, 0);
      wr(la(9), 0);
   endtask

   task automatic t_contention();
      cyc(1, 0, la(10), 0, 1, 0, la(10), 0);
      chk("R6 port0 wins tie", r0, 0);
      chk("R6 port1 loses tie", r1, 1);
      rd(la(10)); chk("R6 lock taken after tie", r0, 1);
      wr(la(10), 0);
      cyc(1, 0, la(11), 0, 1, 0, la(12), 0);
      chk("R6 distinct lock port0", r0, 0);
      chk("R6 distinct lock port1", r1, 0);
      wr(la(11), 0); wr(la(12), 0);
   endtask

   task automatic t_same_cycle();
      cyc(0, 1, la(13), 0, 1, 0, la(13), 0);
      chk("R7 grant beats release reader", r1, 0);
      rd(la(13)); chk("R7 lock ends taken", r0, 1);
      cyc(1, 0, la(13), 0, 0, 1, la(13), 0);
      chk("R7 reader of held lock gets 1", r0, 1);
      rd(la(13)); chk("R7 release wins on held lock", r0, 0);
      wr(la(13), 0);
   endtask

   task automatic t_unmapped();
      rd(la(NL));       chk("R8 one past last lock reads 0", r0, 0);
      rd(la(NL));       chk("R8 past-end read took nothing", r0, 0);
      rd(AW'(12'h802)); chk("R8 misaligned reads 0", r0, 0);
      rd(AW'(12'h010)); chk("R8 unmapped low offset reads 0", r0, 0);
      rd(la(0));
      wr(AW'(12'h802), 0);
      wr(la(NL), 0);
      rd(la(0));        chk("R8 stray writes did not release", r0, 1);
      wr(la(0), 0);
   endtask

   task automatic t_last_lock();
      rd(la(NL-1)); chk("R10 last lock acquire", r0, 0);
      rd(la(NL-1)); chk("R10 last lock taken", r0, 1);
      wr(la(NL-1), 0);
      rd(la(NL-1)); chk("R10 last lock released", r0, 0);
   endtask

   task automatic t_reset_clears();
      rd(la(1)); rd(la(2));
      do_reset();
      rd(la(1)); chk("R9 reset frees lock 1", r0, 0);
      rd(la(2)); chk("R9 reset frees lock 2", r0, 0);
      rd(la(NL-1)); chk("R9 reset frees last lock", r0, 0);
   endtask

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      do_reset();
      t_reset_state();
      t_acquire_release();
      t_nonzero();
      t_status();
      t_contention();
      t_same_cycle();
      t_unmapped();
      t_last_lock();
      t_reset_clears();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule